// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This unit serves one hart. It keeps three pieces of state: a software-interrupt flag, a 64-bit compare value and a 64-bit time counter. Software reaches them through a simple register port. Each request carries an offset, a read/write flag, write data and an access-size code. The unit answers every request one cycle later, with read data or an access fault.

The time counter advances by one on every cycle in which the tick input is high. Two level outputs report pending interrupts. The software interrupt follows the stored flag. The timer interrupt is high whenever the compare value is not greater than the time counter, using an unsigned comparison.

Each register accepts only a fixed set of exact, aligned access sizes. Every other combination is refused with a fault and changes nothing.

Top module: `ctmr_unit`

## Requirements
- R1: After reset the time counter is 0, the software flag is 0 and the compare value is all ones. Both interrupt outputs are low and no response is signalled.
- R2: The software flag sits at offset 0x0000. It accepts 4-byte (size code 2) and 8-byte (size code 3) writes, which load it from bit 0 of the write data. irq_sw_o shows the flag from the cycle after the write.
- R3: A 4-byte or 8-byte read at offset 0x0000 returns the software flag in bit 0, with all other data bits zero.
- R4: The compare value sits at offset 0x4000. Only 8-byte reads and writes are accepted there; a write replaces all 64 bits.
- R5: The time counter sits at offset 0xBFF8 and is read-only. Any write to it raises a store fault and leaves the counter unchanged.
- R6: A request with any other offset, or with a size not allowed for its register, faults. A read raises the load fault and a write raises the store fault. Read data is zero and no state changes. Size codes are 0=1, 1=2, 2=4 and 3=8 bytes.
- R7: The time counter increases by exactly 1 in each cycle with tick_i high and holds otherwise. An 8-byte read at 0xBFF8 returns the value held before that cycle's tick.
- R8: irq_tmr_o equals (compare <= time), unsigned. It is taken from the values present after each clock edge, so it reflects a compare write or a tick from the next cycle.
- R9: Every request with req_vld_i high produces rsp_vld_o high exactly one cycle later, with data and fault flags in that same cycle. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance the time counter by one |
| req_vld_i | input | 1 | Request strobe |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset within the unit |
| req_size_i | input | 2 | Access size code (0=1B, 1=2B, 2=4B, 3=8B) |
| req_wdata_i | input | DATA_W | Write data |
| rsp_vld_o | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata_o | output | DATA_W | Read data, zero on writes and faults |
| rsp_ld_fault_o | output | 1 | Load access fault |
| rsp_st_fault_o | output | 1 | Store access fault |
| irq_sw_o | output | 1 | Software interrupt pending |
| irq_tmr_o | output | 1 | Timer interrupt pending |

## Verification
A corrupted time counter shows up on the next 8-byte read at 0xBFF8. It also shows as a timer-interrupt edge one or more cycles away from where the compare value puts it. A wrong compare value or a misdecoded write appears on the readback one cycle after the request, or as irq_tmr_o disagreeing with the modelled inequality in the cycle after the write. Decode errors show as a fault flag that is wrongly raised or missing on the response cycle, and as state that a refused write should not have touched.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

   typedef enum logic [1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_B8 = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_SW   = 2'd1,
      SEL_CMP  = 2'd2,
      SEL_TIME = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/ctmr_decode.sv
module ctmr_decode
   import ctmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] OFF_SW   = 'h0000,
   parameter logic [ADDR_W-1:0] OFF_CMP  = 'h4000,
   parameter logic [ADDR_W-1:0] OFF_TIME = 'hBFF8
) (
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   output reg_sel_e          sel_o,
   output logic              legal_o
);

   acc_size_e sz;
   assign sz = acc_size_e'(size_i);

   always_comb begin
      sel_o   = SEL_NONE;
      legal_o = 1'b0;
      if (addr_i == OFF_SW) begin
         sel_o   = SEL_SW;
         legal_o = (sz == SZ_B4) || (sz == SZ_B8);
      end else if (addr_i == OFF_CMP) begin
         sel_o   = SEL_CMP;
         legal_o = (sz == SZ_B8);
      end else if (addr_i == OFF_TIME) begin
         sel_o   = SEL_TIME;
         legal_o = (sz == SZ_B8) && !wr_i;
      end
   end

endmodule

// File: rtl/ctmr_timebase.sv
module ctmr_timebase #(
   parameter int unsigned W         = 64,
   parameter bit          CMP_SPLIT = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         cmp_we_i,
   input  logic [W-1:0] cmp_wdata_i,
   output logic [W-1:0] time_o,
   output logic [W-1:0] cmp_o,
   output logic         pend_o
);

   localparam int unsigned HALF = W / 2;

   logic [W-1:0] time_q, time_d, cmp_q, cmp_d;
   logic         pend_q, le_d;

   assign time_d = time_q + W'(tick_i);
   assign cmp_d  = cmp_we_i ? cmp_wdata_i : cmp_q;

   generate
      if (CMP_SPLIT) begin : g_cmp_split
         logic hi_lt, hi_eq, lo_le;
         assign hi_lt = cmp_d[W-1:HALF] <  time_d[W-1:HALF];
         assign hi_eq = cmp_d[W-1:HALF] == time_d[W-1:HALF];
         assign lo_le = cmp_d[HALF-1:0] <= time_d[HALF-1:0];
         assign le_d  = hi_lt || (hi_eq && lo_le);
      end else begin : g_cmp_flat
         assign le_d = cmp_d <= time_d;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         time_q <= '0;
         cmp_q  <= '1;
         pend_q <= 1'b0;
      end else begin
         time_q <= time_d;
         cmp_q  <= cmp_d;
         pend_q <= le_d;
      end
   end

   assign time_o = time_q;
   assign cmp_o  = cmp_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/ctmr_resp.sv
module ctmr_resp
   import ctmr_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         vld_i,
   input  logic         wr_i,
   input  logic         legal_i,
   input  reg_sel_e     sel_i,
   input  logic         sw_i,
   input  logic [W-1:0] cmp_i,
   input  logic [W-1:0] time_i,
   output logic         rsp_vld_o,
   output logic [W-1:0] rdata_o,
   output logic         ld_fault_o,
   output logic         st_fault_o
);

   logic [W-1:0] rd_d;

   always_comb begin
      rd_d = '0;
      if (vld_i && !wr_i && legal_i) begin
         unique case (sel_i)
            SEL_SW:   rd_d = {{(W-1){1'b0}}, sw_i};
            SEL_CMP:  rd_d = cmp_i;
            SEL_TIME: rd_d = time_i;
            default:  rd_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_vld_o  <= 1'b0;
         rdata_o    <= '0;
         ld_fault_o <= 1'b0;
         st_fault_o <= 1'b0;
      end else begin
         rsp_vld_o  <= vld_i;
         rdata_o    <= rd_d;
         ld_fault_o <= vld_i && !wr_i && !legal_i;
         st_fault_o <= vld_i &&  wr_i && !legal_i;
      end
   end

endmodule

// File: rtl/ctmr_unit.sv
module ctmr_unit
   import ctmr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 64,
   parameter logic [ADDR_W-1:0] OFF_SW   = 'h0000,
   parameter logic [ADDR_W-1:0] OFF_CMP  = 'h4000,
   parameter logic [ADDR_W-1:0] OFF_TIME = 'hBFF8,
   parameter bit          CMP_SPLIT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              req_vld_i,
   input  logic              req_wr_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [1:0]        req_size_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              rsp_vld_o,
   output logic [DATA_W-1:0] rsp_rdata_o,
   output logic              rsp_ld_fault_o,
   output logic              rsp_st_fault_o,
   output logic              irq_sw_o,
   output logic              irq_tmr_o
);

   if (DATA_W != 64) begin : g_bad_width
      $error("ctmr_unit: DATA_W must be 64");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("ctmr_unit: ADDR_W must cover offset 0xBFF8");
   end
   if ((OFF_SW % 8) != 0 || (OFF_CMP % 8) != 0 || (OFF_TIME % 8) != 0) begin : g_bad_align
      $error("ctmr_unit: register offsets must be 8-byte aligned");
   end

   reg_sel_e          sel;
   logic              legal;
   logic              sw_q;
   logic              sw_we, cmp_we;
   logic [DATA_W-1:0] time_q, cmp_q;

   ctmr_decode #(
      .ADDR_W  (ADDR_W),
      .OFF_SW  (OFF_SW),
      .OFF_CMP (OFF_CMP),
      .OFF_TIME(OFF_TIME)
   ) u_decode (
      .wr_i   (req_wr_i),
      .addr_i (req_addr_i),
      .size_i (req_size_i),
      .sel_o  (sel),
      .legal_o(legal)
   );

   assign sw_we  = req_vld_i && req_wr_i && legal && (sel == SEL_SW);
   assign cmp_we = req_vld_i && req_wr_i && legal && (sel == SEL_CMP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sw_q <= 1'b0;
      else if (sw_we) sw_q <= req_wdata_i[0];
   end

   ctmr_timebase #(
      .W        (DATA_W),
      .CMP_SPLIT(CMP_SPLIT)
   ) u_timebase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .cmp_we_i   (cmp_we),
      .cmp_wdata_i(req_wdata_i),
      .time_o     (time_q),
      .cmp_o      (cmp_q),
      .pend_o     (irq_tmr_o)
   );

   ctmr_resp #(
      .W(DATA_W)
   ) u_resp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .vld_i     (req_vld_i),
      .wr_i      (req_wr_i),
      .legal_i   (legal),
      .sel_i     (sel),
      .sw_i      (sw_q),
      .cmp_i     (cmp_q),
      .time_i    (time_q),
      .rsp_vld_o (rsp_vld_o),
      .rdata_o   (rsp_rdata_o),
      .ld_fault_o(rsp_ld_fault_o),
      .st_fault_o(rsp_st_fault_o)
   );

   assign irq_sw_o = sw_q;

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 64,
   parameter logic [ADDR_W-1:0] OFF_SW   = 'h0000,
   parameter logic [ADDR_W-1:0] OFF_TIME = 'hBFF8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic              req_vld_i,
   input logic              req_wr_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic [1:0]        req_size_i,
   input logic [DATA_W-1:0] req_wdata_i,
   input logic              rsp_vld_o,
   input logic              rsp_ld_fault_o,
   input logic              rsp_st_fault_o,
   input logic              irq_sw_o,
   input logic              irq_tmr_o,
   input logic [DATA_W-1:0] time_q,
   input logic [DATA_W-1:0] cmp_q
);

   p_rsp_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_vld_i |=> rsp_vld_o);

   p_no_stray_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_vld_i |=> !rsp_vld_o);

   p_time_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> time_q == $past(time_q) + DATA_W'(1));

   p_time_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(time_q));

   p_tmr_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_tmr_o == (cmp_q <= time_q));

   p_fault_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rsp_ld_fault_o && rsp_st_fault_o));

   p_time_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_vld_i && req_wr_i && req_addr_i == OFF_TIME) |=> rsp_st_fault_o);

   p_sw_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_vld_i && req_wr_i && req_addr_i == OFF_SW && req_size_i >= 2'd2)
      |=> irq_sw_o == $past(req_wdata_i[0]));

endmodule

bind ctmr_unit ctmr_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .OFF_SW  (OFF_SW),
   .OFF_TIME(OFF_TIME)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .tick_i        (tick_i),
   .req_vld_i     (req_vld_i),
   .req_wr_i      (req_wr_i),
   .req_addr_i    (req_addr_i),
   .req_size_i    (req_size_i),
   .req_wdata_i   (req_wdata_i),
   .rsp_vld_o     (rsp_vld_o),
   .rsp_ld_fault_o(rsp_ld_fault_o),
   .rsp_st_fault_o(rsp_st_fault_o),
   .irq_sw_o      (irq_sw_o),
   .irq_tmr_o     (irq_tmr_o),
   .time_q        (time_q),
   .cmp_q         (cmp_q)
);

// File: tb/test_ctmr_unit.sv
module test_ctmr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        req_vld = 1'b0;
   logic        req_wr = 1'b0;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_vld, rsp_lf, rsp_sf, irq_sw, irq_tmr;
   logic [63:0] rsp_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   logic [63:0] m_time, m_cmp;
   logic        m_sw;

   always #4 clk = ~clk;

   ctmr_unit i_ctmr_unit (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .tick_i        (tick),
      .req_vld_i     (req_vld),
      .req_wr_i      (req_wr),
      .req_addr_i    (req_addr),
      .req_size_i    (req_size),
      .req_wdata_i   (req_wdata),
      .rsp_vld_o     (rsp_vld),
      .rsp_rdata_o   (rsp_rdata),
      .rsp_ld_fault_o(rsp_lf),
      .rsp_st_fault_o(rsp_sf),
      .irq_sw_o      (irq_sw),
      .irq_tmr_o     (irq_tmr)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic bit exp_legal(bit wr, logic [15:0] a, logic [1:0] sz);
      if (a == 16'h0000) return sz >= 2'd2;
      if (a == 16'h4000) return sz == 2'd3;
      if (a == 16'hBFF8) return (sz == 2'd3) && !wr;
      return 1'b0;
   endfunction

   // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
   task automatic step(bit v, bit wr, logic [15:0] a, logic [1:0] sz,
                       logic [63:0] wd, bit tk);
      logic [63:0] e_rd;
      bit          ok, e_lf, e_sf;
      string       tg;
      ok   = exp_legal(wr, a, sz);
      e_rd = '0;
      if (v && !wr && ok) begin
         if (a == 16'h0000)      e_rd = {63'b0, m_sw};
         else if (a == 16'h4000) e_rd = m_cmp;
         else                    e_rd = m_time;
      end
      e_lf = v && !wr && !ok;
      e_sf = v &&  wr && !ok;
      if (!ok)                tg = (a == 16'hBFF8 && wr) ? "R5" : "R6";
      else if (a == 16'h0000) tg = wr ? "R2" : "R3";
      else if (a == 16'h4000) tg = "R4";
      else                    tg = "R7";
      req_vld = v; req_wr = wr; req_addr = a; req_size = sz; req_wdata = wd; tick = tk;
      if (v && wr && ok) begin
         if (a == 16'h0000) m_sw = wd[0];
         else               m_cmp = wd;
      end
      if (tk) m_time = m_time + 64'd1;
      @(posedge clk);
      @(negedge clk);
      chk("R9 rsp_vld", 64'(rsp_vld), 64'(v));
      if (v) begin
         chk($sformatf("%s ld_fault", tg), 64'(rsp_lf), 64'(e_lf));
         chk($sformatf("%s st_fault", tg), 64'(rsp_sf), 64'(e_sf));
         chk($sformatf("%s rdata", tg), rsp_rdata, e_rd);
      end
      chk("R2 irq_sw", 64'(irq_sw), 64'(m_sw));
      chk("R8 irq_tmr", 64'(irq_tmr), 64'(m_cmp <= m_time));
      req_vld = 1'b0;
      tick    = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      m_time = '0; m_cmp = '1; m_sw = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 rsp_vld", 64'(rsp_vld), 64'd0);
      chk("R1 irq_sw", 64'(irq_sw), 64'd0);
      chk("R1 irq_tmr", 64'(irq_tmr), 64'd0);
      rst_n = 1'b1;
      // R1: state after reset read back
      step(1, 0, 16'hBFF8, 2'd3, '0, 0);
      step(1, 0, 16'h4000, 2'd3, '0, 0);
      step(1, 0, 16'h0000, 2'd3, '0, 0);
      // R7: ticks, read returns pre-tick value
      step(0, 0, 16'h0, 2'd0, '0, 1);
      step(0, 0, 16'h0, 2'd0, '0, 1);
      step(1, 0, 16'hBFF8, 2'd3, '0, 1);
      // R5: write to time refused, value unchanged
      step(1, 1, 16'hBFF8, 2'd3, 64'h1234, 0);
      step(1, 0, 16'hBFF8, 2'd3, '0, 0);
      step(1, 0, 16'hBFF8, 2'd2, '0, 0);
      // R2/R3: software flag widths
      step(1, 1, 16'h0000, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      step(1, 0, 16'h0000, 2'd2, '0, 0);
      step(1, 1, 16'h0000, 2'd1, 64'h0, 0);
      step(1, 0, 16'h0000, 2'd0, '0, 0);
      step(1, 1, 16'h0000, 2'd3, 64'h2, 0);
      // R6: misaligned / unmapped offsets
      step(1, 1, 16'h0004, 2'd2, 64'h1, 0);
      step(1, 0, 16'h4004, 2'd2, '0, 0);
      step(1, 1, 16'hBFFC, 2'd2, '0, 0);
      // R4: compare only at 8 bytes; a 4-byte write leaves it intact
      step(1, 1, 16'h4000, 2'd2, 64'h0, 0);
      step(1, 0, 16'h4000, 2'd3, '0, 0);
      // R8: compare at 0 pends immediately, then future value with ticks
      step(1, 1, 16'h4000, 2'd3, 64'h0, 0);
      step(1, 1, 16'h4000, 2'd3, m_time + 64'd2, 1);
      step(0, 0, 16'h0, 2'd0, '0, 1);
      step(0, 0, 16'h0, 2'd0, '0, 1);
      step(1, 1, 16'h4000, 2'd3, 64'hFFFF_FFFF_0000_0000, 1);
      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         logic [63:0] wd;
         int unsigned pick;
         pick = $urandom_range(0, 7);
         case (pick)
            0, 1: a = 16'h0000;
            2, 3: a = 16'h4000;
            4:    a = 16'hBFF8;
            5:    a = 16'h0004;
            6:    a = 16'hBFFC;
            default: a = 16'($urandom);
         endcase
         wd = {$urandom, $urandom};
         if (a == 16'h4000 && $urandom_range(0, 3) != 0)
            wd = m_time + 64'($urandom_range(0, 30));
         step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)), a,
              2'($urandom_range(0, 3)), wd, bit'($urandom_range(0, 1)));
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule